// File: doc/BRIEF.md
# Accelerator Control and Fault-Mask Slave

This block sits between a host processor and a compute kernel. The host talks to it over a 32-bit AXI4-Lite slave port with byte strobes. The block runs the kernel's start/done/idle/ready handshake and raises one interrupt line from two event sources. It also holds the scalar fault-injection settings the kernel reads: an input-fault flag, a weight-fault flag and a 3-bit index that picks the faulty bit.

A 64-entry, one-bit-per-entry fault mask completes the register space. The kernel sees it as an 8x8 grid, where entry index = row*8 + column. The kernel reads the mask combinationally through a 6-bit index port. The host sees it as sixteen 32-bit words, each word packing four entries, one per byte lane.

The host starts a run by setting the start bit. The kernel accepts the start by pulsing ready, and signals completion by pulsing done. The host either polls the control register or waits for the interrupt. With auto-restart set, the block starts the kernel again after each completion without help from the host.

Top module: `accel_ctrl_slave`

## Requirements
- R1: After reset, every register and every mask bit is zero, `irq`, `kern_start`, `s_bvalid` and `s_rvalid` are low, and bit 2 of the control word (offset 0x00) mirrors the `kern_idle` input at all times.
- R2: Writing 1 to bit 0 of offset 0x00 raises `kern_start` and sets bit 0 of the control word. The bit stays set until the kernel pulses `kern_ready` while start is high, and then it clears. Writing 0 to bit 0 has no effect.
- R3: While auto-restart (bit 7 of offset 0x00, read/write) is set, a `kern_done` pulse raises `kern_start` again on the next cycle.
- R4: Bit 1 (done) and bit 3 (ready) of the control word latch on `kern_done` and `kern_ready` pulses. A read of offset 0x00 clears both. A pulse in the same cycle as the clearing read wins: the read returns the old value and the bit stays set.
- R5: Offset 0x04 bit 0 is the global interrupt enable. Offset 0x08 bits 1:0 enable the done (bit 0) and ready (bit 1) sources. `irq` is high exactly when the global enable is set and some status bit is set together with its source enable. Bit 9 of the control word mirrors `irq`.
- R6: Offset 0x0C holds status bits: bit 0 latches on `kern_done` and bit 1 latches on `kern_ready`, whatever the enables are. Both bits clear when offset 0x0C is read.
- R7: Bit 0 of offset 0x10 drives `cfg_in_fault`, bit 0 of 0x18 drives `cfg_wt_fault`, and bits 2:0 of 0x20 drive `cfg_fault_bit`. All three read back as written.
- R8: The mask word at byte offset 0x40+4n holds entries 4n, 4n+1, 4n+2 and 4n+3 at bits 0, 8, 16 and 24. `mask_bit` returns entry `mask_idx` in the same cycle.
- R9: A write updates only the byte lanes whose `s_wstrb` bit is set. Each mask entry is written only when the strobe of its own lane is set.
- R10: Reserved offsets (0x14, 0x1C, 0x24 and any other unmapped word) and unused bits of mapped words read as zero. Writes to them have no effect. Every response is OKAY (2'b00).
- R11: A read and a write may be in flight together and both complete. Write address and write data may arrive in either order. `s_bvalid` rises only after both have been captured. `s_bvalid` and `s_rvalid` stay high, with stable read data, until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 7 | Write address (byte) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 7 | Read address (byte) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| kern_start | output | 1 | Start request to the kernel |
| kern_done | input | 1 | Kernel completion pulse |
| kern_idle | input | 1 | Kernel idle level |
| kern_ready | input | 1 | Kernel start-accept pulse |
| irq | output | 1 | Interrupt request |
| cfg_in_fault | output | 1 | Input-fault flag |
| cfg_wt_fault | output | 1 | Weight-fault flag |
| cfg_fault_bit | output | 3 | Faulty bit index |
| mask_idx | input | 6 | Mask entry index (row*8+column) |
| mask_bit | output | 1 | Mask entry value |

## Verification
Two functions can fall in the same clock edge: the host's clear-on-read of the control word and the kernel's done pulse. The bench forks a read of offset 0x00 with a done pulse so that both are sampled at one edge. The scoreboard then expects the read to show done clear, the next read to show it set, and the read after that to show it cleared again. The same forking places a read of 0x20 under a split write to 0x20, whose address arrives a cycle before its data. The read must return the old value, and the write must land afterwards.

// File: rtl/accel_ctrl_pkg.sv
package accel_ctrl_pkg;
   // word indices (byte offset / 4) of the scalar registers
   localparam int unsigned WD_CTRL = 0;
   localparam int unsigned WD_GIE  = 1;
   localparam int unsigned WD_IER  = 2;
   localparam int unsigned WD_ISR  = 3;
   localparam int unsigned WD_INF  = 4;
   localparam int unsigned WD_WTF  = 6;
   localparam int unsigned WD_FBIT = 8;

   // bit positions inside the control word
   localparam int unsigned CB_START = 0;
   localparam int unsigned CB_DONE  = 1;
   localparam int unsigned CB_IDLE  = 2;
   localparam int unsigned CB_RDY   = 3;
   localparam int unsigned CB_AUTO  = 7;
   localparam int unsigned CB_IRQ   = 9;

   // event source positions in enable and status registers
   localparam int unsigned SRC_DONE = 0;
   localparam int unsigned SRC_RDY  = 1;

   localparam logic [1:0] RESP_OKAY = 2'b00;

   typedef struct packed {
      logic start;
      logic auto_rs;
      logic done;
      logic ready;
   } ctl_state_t;
endpackage

// File: rtl/accel_axil_port.sv
module accel_axil_port
   import accel_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned STRB_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [DATA_W-1:0] s_wdata,
   input  logic [STRB_W-1:0] s_wstrb,
   input  logic              s_wvalid,
   output logic              s_wready,
   output logic [1:0]        s_bresp,
   output logic              s_bvalid,
   input  logic              s_bready,
   input  logic [ADDR_W-1:0] s_araddr,
   input  logic              s_arvalid,
   output logic              s_arready,
   output logic [DATA_W-1:0] s_rdata,
   output logic [1:0]        s_rresp,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [STRB_W-1:0] wr_strb,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_word
);
   logic              aw_held, w_held;
   logic [ADDR_W-1:0] aw_q;
   logic [DATA_W-1:0] wd_q;
   logic [STRB_W-1:0] ws_q;

   assign s_awready = !aw_held && !s_bvalid;
   assign s_wready  = !w_held && !s_bvalid;
   assign wr_en     = aw_held && w_held && !s_bvalid;
   assign wr_addr   = aw_q;
   assign wr_data   = wd_q;
   assign wr_strb   = ws_q;
   assign s_bresp   = RESP_OKAY;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aw_held  <= 1'b0;
         w_held   <= 1'b0;
         aw_q     <= '0;
         wd_q     <= '0;
         ws_q     <= '0;
         s_bvalid <= 1'b0;
      end else begin
         if (s_awvalid && s_awready) begin
            aw_held <= 1'b1;
            aw_q    <= s_awaddr;
         end
         if (s_wvalid && s_wready) begin
            w_held <= 1'b1;
            wd_q   <= s_wdata;
            ws_q   <= s_wstrb;
         end
         if (wr_en) begin
            aw_held  <= 1'b0;
            w_held   <= 1'b0;
            s_bvalid <= 1'b1;
         end else if (s_bready) begin
            s_bvalid <= 1'b0;
         end
      end
   end

   assign s_arready = !s_rvalid;
   assign rd_en     = s_arvalid && s_arready;
   assign rd_addr   = s_araddr;
   assign s_rresp   = RESP_OKAY;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_rvalid <= 1'b0;
         s_rdata  <= '0;
      end else if (rd_en) begin
         s_rvalid <= 1'b1;
         s_rdata  <= rd_word;
      end else if (s_rready) begin
         s_rvalid <= 1'b0;
      end
   end

   // R11
   bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_bvalid && !s_bready |=> s_bvalid);
   // R11
   rvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
   // R11
   bvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(s_bvalid) |-> $past(aw_held && w_held));
endmodule

// File: rtl/accel_ctrl_regs.sv
module accel_ctrl_regs
   import accel_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned FBIT_W = 3,
   localparam int unsigned STRB_W = DATA_W / 8,
   localparam int unsigned WA_W   = ADDR_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [STRB_W-1:0] wr_strb,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              kern_done,
   input  logic              kern_ready,
   input  logic              kern_idle,
   output logic              kern_start,
   output logic              irq,
   output logic              cfg_in_fault,
   output logic              cfg_wt_fault,
   output logic [FBIT_W-1:0] cfg_fault_bit,
   output logic [DATA_W-1:0] rd_word
);
   generate
      if (FBIT_W > 8 || FBIT_W == 0) begin : g_bad_fbit
         $error("FBIT_W must fit in byte lane 0");
      end
      if (DATA_W <= CB_IRQ) begin : g_bad_width
         $error("DATA_W too narrow for the control word");
      end
   endgenerate

   ctl_state_t        st_q;
   logic              gie_q;
   logic [1:0]        ier_q, isr_q;
   logic              inf_q, wtf_q;
   logic [FBIT_W-1:0] fbit_q;

   logic [WA_W-1:0] wa, ra;
   logic            we0, ctl_we, ctl_re, isr_re;

   assign wa     = wr_addr[ADDR_W-1:2];
   assign ra     = rd_addr[ADDR_W-1:2];
   assign we0    = wr_en && wr_strb[0];
   assign ctl_we = we0 && (wa == WA_W'(WD_CTRL));
   assign ctl_re = rd_en && (ra == WA_W'(WD_CTRL));
   assign isr_re = rd_en && (ra == WA_W'(WD_ISR));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= '0;
         gie_q  <= 1'b0;
         ier_q  <= '0;
         isr_q  <= '0;
         inf_q  <= 1'b0;
         wtf_q  <= 1'b0;
         fbit_q <= '0;
      end else begin
         // start: cleared by the kernel handshake, set by host or auto-restart
         if (st_q.start && kern_ready) st_q.start <= 1'b0;
         if ((st_q.auto_rs && kern_done) || (ctl_we && wr_data[CB_START]))
            st_q.start <= 1'b1;
         if (ctl_we) st_q.auto_rs <= wr_data[CB_AUTO];
         // latched events: a pulse beats a clearing read
         if (ctl_re) begin
            st_q.done  <= 1'b0;
            st_q.ready <= 1'b0;
         end
         if (kern_done)  st_q.done  <= 1'b1;
         if (kern_ready) st_q.ready <= 1'b1;
         if (isr_re) isr_q <= '0;
         if (kern_done)  isr_q[SRC_DONE] <= 1'b1;
         if (kern_ready) isr_q[SRC_RDY]  <= 1'b1;
         if (we0 && wa == WA_W'(WD_GIE))  gie_q  <= wr_data[0];
         if (we0 && wa == WA_W'(WD_IER))  ier_q  <= wr_data[1:0];
         if (we0 && wa == WA_W'(WD_INF))  inf_q  <= wr_data[0];
         if (we0 && wa == WA_W'(WD_WTF))  wtf_q  <= wr_data[0];
         if (we0 && wa == WA_W'(WD_FBIT)) fbit_q <= wr_data[FBIT_W-1:0];
      end
   end

   assign kern_start    = st_q.start;
   assign irq           = gie_q && |(isr_q & ier_q);
   assign cfg_in_fault  = inf_q;
   assign cfg_wt_fault  = wtf_q;
   assign cfg_fault_bit = fbit_q;

   always_comb begin
      rd_word = '0;
      if (ra == WA_W'(WD_CTRL)) begin
         rd_word[CB_START] = st_q.start;
         rd_word[CB_DONE]  = st_q.done;
         rd_word[CB_IDLE]  = kern_idle;
         rd_word[CB_RDY]   = st_q.ready;
         rd_word[CB_AUTO]  = st_q.auto_rs;
         rd_word[CB_IRQ]   = irq;
      end else if (ra == WA_W'(WD_GIE)) begin
         rd_word[0] = gie_q;
      end else if (ra == WA_W'(WD_IER)) begin
         rd_word[1:0] = ier_q;
      end else if (ra == WA_W'(WD_ISR)) begin
         rd_word[1:0] = isr_q;
      end else if (ra == WA_W'(WD_INF)) begin
         rd_word[0] = inf_q;
      end else if (ra == WA_W'(WD_WTF)) begin
         rd_word[0] = wtf_q;
      end else if (ra == WA_W'(WD_FBIT)) begin
         rd_word[FBIT_W-1:0] = fbit_q;
      end
   end

   // R2
   start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kern_start && kern_ready && !kern_done && !(ctl_we && wr_data[CB_START])
      |=> !kern_start);
   // R2
   start_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kern_start && !kern_ready |=> kern_start);
   // R3
   auto_rs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_q.auto_rs && kern_done |=> kern_start);
   // R4
   done_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kern_done |=> st_q.done);
   // R4
   done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_re && !kern_done |=> !st_q.done);
   // R5
   irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gie_q && ier_q[SRC_DONE] && kern_done && !(we0 && (wa == WA_W'(WD_GIE) || wa == WA_W'(WD_IER)))
      |=> irq);
   // R6
   isr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      isr_re && !kern_done && !kern_ready |=> isr_q == 2'b00);
endmodule

// File: rtl/accel_fault_mask.sv
module accel_fault_mask #(
   parameter int unsigned ADDR_W  = 7,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned BASE    = 64,
   localparam int unsigned STRB_W = DATA_W / 8,
   localparam int unsigned LANES  = DATA_W / 8,
   localparam int unsigned WORDS  = ENTRIES / LANES,
   localparam int unsigned WA_W   = ADDR_W - 2,
   localparam int unsigned BASE_W = BASE / 4,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [STRB_W-1:0] wr_strb,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_word,
   input  logic [IDX_W-1:0]  mask_idx,
   output logic              mask_bit
);
   generate
      if (DATA_W % 8 != 0) begin : g_bad_data
         $error("DATA_W must be a whole number of bytes");
      end
      if (ENTRIES % LANES != 0) begin : g_bad_entries
         $error("ENTRIES must fill whole words");
      end
      if (BASE % 4 != 0 || BASE_W + WORDS > (1 << WA_W)) begin : g_bad_base
         $error("mask window must be word aligned and inside the address space");
      end
   endgenerate

   logic [ENTRIES-1:0] bits_q, sel_v, din_v;
   logic [WA_W-1:0]    wa, ra;
   logic               w_hit, r_hit;
   int unsigned        w_idx, r_idx;

   assign wa    = wr_addr[ADDR_W-1:2];
   assign ra    = rd_addr[ADDR_W-1:2];
   assign w_hit = (int'(wa) >= BASE_W) && (int'(wa) < BASE_W + WORDS);
   assign r_hit = (int'(ra) >= BASE_W) && (int'(ra) < BASE_W + WORDS);
   assign w_idx = w_hit ? int'(wa) - BASE_W : 0;
   assign r_idx = r_hit ? int'(ra) - BASE_W : 0;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      for (genvar b = 0; b < LANES; b++) begin : g_lane
         localparam int unsigned E = w * LANES + b;
         assign sel_v[E] = wr_en && w_hit && (w_idx == w) && wr_strb[b];
         assign din_v[E] = wr_data[8*b];

         // R9
         lane_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sel_v[E] |=> bits_q[E] == $past(din_v[E]));
         // R9
         lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !sel_v[E] |=> $stable(bits_q[E]));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bits_q <= '0;
      else        bits_q <= (bits_q & ~sel_v) | (din_v & sel_v);
   end

   always_comb begin
      rd_word = '0;
      if (r_hit) begin
         for (int b = 0; b < LANES; b++) rd_word[8*b] = bits_q[r_idx*LANES + b];
      end
   end

   assign mask_bit = bits_q[mask_idx];
endmodule

// File: rtl/accel_ctrl_slave.sv
module accel_ctrl_slave #(
   parameter int unsigned ADDR_W       = 7,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned FBIT_W       = 3,
   parameter int unsigned MASK_ENTRIES = 64,
   parameter int unsigned MASK_BASE    = 64,
   localparam int unsigned STRB_W = DATA_W / 8,
   localparam int unsigned IDX_W  = $clog2(MASK_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [DATA_W-1:0] s_wdata,
   input  logic [STRB_W-1:0] s_wstrb,
   input  logic              s_wvalid,
   output logic              s_wready,
   output logic [1:0]        s_bresp,
   output logic              s_bvalid,
   input  logic              s_bready,
   input  logic [ADDR_W-1:0] s_araddr,
   input  logic              s_arvalid,
   output logic              s_arready,
   output logic [DATA_W-1:0] s_rdata,
   output logic [1:0]        s_rresp,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic              kern_start,
   input  logic              kern_done,
   input  logic              kern_idle,
   input  logic              kern_ready,
   output logic              irq,
   output logic              cfg_in_fault,
   output logic              cfg_wt_fault,
   output logic [FBIT_W-1:0] cfg_fault_bit,
   input  logic [IDX_W-1:0]  mask_idx,
   output logic              mask_bit
);
   logic              wr_en, rd_en;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic [DATA_W-1:0] wr_data, rd_word, regs_word, mask_word;
   logic [STRB_W-1:0] wr_strb;

   accel_axil_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
      .clk, .rst_n,
      .s_awaddr, .s_awvalid, .s_awready,
      .s_wdata, .s_wstrb, .s_wvalid, .s_wready,
      .s_bresp, .s_bvalid, .s_bready,
      .s_araddr, .s_arvalid, .s_arready,
      .s_rdata, .s_rresp, .s_rvalid, .s_rready,
      .wr_en, .wr_addr, .wr_data, .wr_strb,
      .rd_en, .rd_addr, .rd_word
   );

   accel_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FBIT_W(FBIT_W)) u_regs (
      .clk, .rst_n,
      .wr_en, .wr_addr, .wr_data, .wr_strb,
      .rd_en, .rd_addr,
      .kern_done, .kern_ready, .kern_idle,
      .kern_start, .irq,
      .cfg_in_fault, .cfg_wt_fault, .cfg_fault_bit,
      .rd_word(regs_word)
   );

   accel_fault_mask #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                      .ENTRIES(MASK_ENTRIES), .BASE(MASK_BASE)) u_mask (
      .clk, .rst_n,
      .wr_en, .wr_addr, .wr_data, .wr_strb,
      .rd_addr, .rd_word(mask_word),
      .mask_idx, .mask_bit
   );

   // the two decoders return zero outside their own windows
   assign rd_word = regs_word | mask_word;
endmodule

// File: tb/accel_ctrl_slave_tb.sv
module accel_ctrl_slave_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  awaddr = '0, araddr = '0;
   logic        awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
   logic [31:0] wdata = '0;
   logic [3:0]  wstrb = '0;
   logic        awready, wready, bvalid, arready, rvalid;
   logic [1:0]  bresp, rresp;
   logic [31:0] rdata;
   logic        kstart, kdone = 1'b0, kidle = 1'b1, kready = 1'b0;
   logic        irq, inf, wtf, mbit;
   logic [2:0]  fbit;
   logic [5:0]  midx = '0;

   int nchk = 0, nerr = 0;
   bit fin = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #4 clk = ~clk;

   accel_ctrl_slave u_dut (
      .clk, .rst_n,
      .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
      .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
      .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(1'b1),
      .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
      .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(1'b1),
      .kern_start(kstart), .kern_done(kdone), .kern_idle(kidle), .kern_ready(kready),
      .irq, .cfg_in_fault(inf), .cfg_wt_fault(wtf), .cfg_fault_bit(fbit),
      .mask_idx(midx), .mask_bit(mbit)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: one read beat per rvalid cycle (rready tied high)
   always @(negedge clk) begin
      if (rst_n && rvalid) begin
         if (exp_q.size() == 0) begin
            chk("R11 unexpected read beat", rdata, 32'hx);
         end else begin
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(t, rdata, e);
            chk("R10 rresp", {30'd0, rresp}, 32'd0);
         end
      end
   end

   task automatic host_rd(input logic [6:0] a, input logic [31:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      araddr = a; arvalid = 1'b1;
      @(posedge clk); #1;
      arvalid = 1'b0;
      @(posedge clk); #1;
   endtask

   // order: 0 together, 1 address first, 2 data first
   task automatic host_wr(input logic [6:0] a, input logic [31:0] d,
                          input logic [3:0] s, input int order);
      if (order != 2) begin awaddr = a; awvalid = 1'b1; end
      if (order != 1) begin wdata = d; wstrb = s; wvalid = 1'b1; end
      @(posedge clk); #1;
      awvalid = 1'b0; wvalid = 1'b0;
      if (order != 0) begin
         chk("R11 bvalid before both halves", {31'd0, bvalid}, 32'd0);
         if (order == 1) begin wdata = d; wstrb = s; wvalid = 1'b1; end
         else begin awaddr = a; awvalid = 1'b1; end
         @(posedge clk); #1;
         awvalid = 1'b0; wvalid = 1'b0;
      end
      for (int i = 0; i < 8 && !bvalid; i++) begin @(posedge clk); #1; end
      chk("R11 bvalid", {31'd0, bvalid}, 32'd1);
      chk("R10 bresp", {30'd0, bresp}, 32'd0);
      @(posedge clk); #1;
   endtask

   task automatic pulse_done();
      kdone = 1'b1; @(posedge clk); #1; kdone = 1'b0;
   endtask
   task automatic pulse_ready();
      kready = 1'b1; @(posedge clk); #1; kready = 1'b0;
   endtask

   task automatic finish_run();
      if (!fin) begin
         fin = 1'b1;
         $display("  Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      nchk++; nerr++;
      $display("FAIL R11 watchdog act=hung exp=complete");
      finish_run();
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      chk("R1 irq", {31'd0, irq}, 0);
      chk("R1 kern_start", {31'd0, kstart}, 0);
      chk("R1 cfg", {27'd0, inf, wtf, fbit}, 0);
      chk("R1 mask_bit", {31'd0, mbit}, 0);
      host_rd(7'h00, 32'h4, "R1 ctrl after reset");
      host_rd(7'h0C, 32'h0, "R1 isr after reset");

      // R7 configuration
      host_wr(7'h10, 32'h1, 4'hF, 0);
      host_wr(7'h18, 32'h1, 4'hF, 0);
      host_wr(7'h20, 32'h5, 4'hF, 0);
      chk("R7 cfg outputs", {27'd0, inf, wtf, fbit}, {27'd0, 1'b1, 1'b1, 3'd5});
      host_rd(7'h20, 32'h5, "R7 fault bit readback");
      host_rd(7'h10, 32'h1, "R7 input fault readback");

      // R9 strobes on scalar registers
      host_wr(7'h20, 32'h2, 4'h0, 0);
      host_rd(7'h20, 32'h5, "R9 no strobes");
      host_wr(7'h20, 32'hFFFFFF02, 4'hE, 0);
      chk("R9 fault bit kept", {29'd0, fbit}, 32'd5);

      // R10 reserved and unused bits
      host_rd(7'h14, 32'h0, "R10 reserved 0x14");
      host_rd(7'h24, 32'h0, "R10 reserved 0x24");
      host_rd(7'h30, 32'h0, "R10 unmapped 0x30");
      host_wr(7'h14, 32'hFFFFFFFF, 4'hF, 0);
      host_rd(7'h14, 32'h0, "R10 reserved write ignored");
      host_wr(7'h10, 32'hFFFFFFFF, 4'hF, 0);
      host_rd(7'h10, 32'h1, "R10 unused bits zero");

      // R8 mask layout
      host_wr(7'h40, 32'h01000101, 4'hF, 0);
      host_wr(7'h7C, 32'h01010000, 4'hF, 0);
      midx = 6'd0;  #1 chk("R8 entry 0", {31'd0, mbit}, 1);
      midx = 6'd1;  #1 chk("R8 entry 1", {31'd0, mbit}, 1);
      midx = 6'd2;  #1 chk("R8 entry 2", {31'd0, mbit}, 0);
      midx = 6'd3;  #1 chk("R8 entry 3", {31'd0, mbit}, 1);
      midx = 6'd61; #1 chk("R8 entry 61", {31'd0, mbit}, 0);
      midx = 6'd62; #1 chk("R8 entry 62", {31'd0, mbit}, 1);
      midx = 6'(7 * 8 + 7); #1 chk("R8 row7 col7", {31'd0, mbit}, 1);
      @(posedge clk); #1;
      host_rd(7'h40, 32'h01000101, "R8 word 0");
      host_rd(7'h7C, 32'h01010000, "R8 word 15");
      host_wr(7'h44, 32'hFEFEFEFF, 4'hF, 0);
      host_rd(7'h44, 32'h00000001, "R10 mask unused bits");
      // R9 lane strobe on mask
      host_wr(7'h40, 32'h0, 4'b0010, 0);
      host_rd(7'h40, 32'h01000001, "R9 mask lane 1 only");

      // R2 start handshake, R4 ready latch, R6 status
      host_wr(7'h00, 32'h1, 4'hF, 0);
      chk("R2 start raised", {31'd0, kstart}, 1);
      host_rd(7'h00, 32'h5, "R2 start readback");
      pulse_ready();
      chk("R2 start cleared by handshake", {31'd0, kstart}, 0);
      host_rd(7'h00, 32'hC, "R4 ready latched");
      host_rd(7'h00, 32'h4, "R4 cleared by read");
      host_rd(7'h0C, 32'h2, "R6 ready status");
      host_rd(7'h0C, 32'h0, "R6 status cleared");

      // R5 interrupt
      host_wr(7'h08, 32'h1, 4'hF, 0);
      host_wr(7'h04, 32'h1, 4'hF, 0);
      chk("R5 irq idle", {31'd0, irq}, 0);
      pulse_done();
      chk("R5 irq raised", {31'd0, irq}, 1);
      host_rd(7'h00, 32'h206, "R5 irq bit in ctrl");
      host_rd(7'h0C, 32'h1, "R6 done status");
      chk("R5 irq drops after status read", {31'd0, irq}, 0);
      host_wr(7'h04, 32'h0, 4'hF, 0);
      pulse_done();
      chk("R5 irq gated by global enable", {31'd0, irq}, 0);
      host_rd(7'h04, 32'h0, "R5 gie readback");
      host_rd(7'h08, 32'h1, "R5 ier readback");
      host_rd(7'h0C, 32'h1, "R6 latches without global enable");
      host_rd(7'h00, 32'h6, "R4 done latched again");

      // R3 auto-restart
      host_wr(7'h00, 32'h81, 4'hF, 0);
      chk("R3 start with auto", {31'd0, kstart}, 1);
      pulse_ready();
      chk("R3 start cleared", {31'd0, kstart}, 0);
      host_rd(7'h00, 32'h8C, "R3 auto bit readback");
      pulse_done();
      chk("R3 restart after done", {31'd0, kstart}, 1);
      host_rd(7'h00, 32'h87, "R3 ctrl after restart");
      host_wr(7'h00, 32'h0, 4'hF, 0);
      chk("R2 writing zero keeps start", {31'd0, kstart}, 1);
      pulse_ready();
      host_rd(7'h00, 32'hC, "R3 auto off, start cleared");
      host_rd(7'h0C, 32'h3, "R6 both sources");

      // R4 done pulse in the same cycle as the clearing read
      fork
         host_rd(7'h00, 32'h4, "R4 read beside done pulse");
         pulse_done();
      join
      host_rd(7'h00, 32'h6, "R4 pulse survived read");
      host_rd(7'h00, 32'h4, "R4 cleared afterwards");

      // R11 overlapping read and split write
      fork
         host_wr(7'h20, 32'h3, 4'hF, 1);
         host_rd(7'h20, 32'h5, "R11 read during split write");
      join
      host_rd(7'h20, 32'h3, "R11 split write landed");
      host_wr(7'h18, 32'h0, 4'hF, 2);
      chk("R11 data-first write", {31'd0, wtf}, 0);
      host_rd(7'h18, 32'h0, "R11 data-first readback");

      // R1 idle mirror
      kidle = 1'b0;
      host_rd(7'h00, 32'h0, "R1 idle follows input");

      repeat (3) @(posedge clk);
      chk("R11 scoreboard drained", exp_q.size(), 0);
      finish_run();
   end
endmodule